// File: doc/BRIEF.md
# Programming Mode Entry Sequencer

This block drives the reset line and the programming-port chip select of a target microcontroller. It steers that target into its SPI flash-programming mode, or back into normal run mode. The target picks its mode from the level of its programming chip select at the moment reset is released. For that reason, on entry the chip select goes active before the reset pulse and stays active through the pulse and the startup wait that follows it.

A controller asks for one of three sequences, each with a single-cycle pulse:

- **Enter** programming mode.
- **Exit** back to run mode: a reset pulse with chip select inactive.
- **Standalone reset**: the reset pulse only, with no chip-select activity and no bus request.

Enter and exit first request the shared SPI bus and wait for a grant. They keep the request raised until the sequence ends, so no other device can use the bus in between. All delays are counted in pulses of a millisecond tick. The block reports busy while a sequence runs and pulses done for one cycle when it ends. Every output comes straight from a register.

Top module: `prog_mode_seq`

## Requirements
- R1: While `rst` is sampled high and on the edge after it, `tgt_reset` is at its inactive level, `prog_cs_n` is 1, and `bus_req`, `busy` and `done` are 0.
- R2: An accepted enter or exit request raises `busy` and `bus_req` on the next edge. `prog_cs_n` stays 1 for as long as `bus_grant` is sampled low. The edge that samples `bus_grant` high starts the next phase; for enter, that edge drives `prog_cs_n` to 0.
- R3: In an enter sequence, `prog_cs_n` stays 0 for `CS_SETUP_TICKS` tick pulses before reset is asserted. Reset then stays asserted for `RST_HOLD_TICKS` tick pulses with `prog_cs_n` still 0. Only tick pulses sampled within a phase count toward that phase.
- R4: After reset is released, `prog_cs_n` stays 0 for `STARTUP_TICKS` tick pulses. The edge that samples the last of those pulses drives `prog_cs_n` to 1 and `bus_req` and `busy` to 0, and drives `done` to 1 for exactly one cycle.
- R5: An exit sequence requests the bus, waits for the grant, then asserts reset for `RST_HOLD_TICKS` tick pulses and waits `STARTUP_TICKS` tick pulses, with `prog_cs_n` at 1 throughout. It ends as in R4.
- R6: A standalone reset asserts reset on the edge after the request, then runs the same hold and startup phases. `bus_req` stays 0 and `prog_cs_n` stays 1 throughout.
- R7: When several requests are sampled together while idle, enter wins over exit, and exit wins over standalone reset.
- R8: A request of any kind sampled while `busy` is 1 has no effect. The running sequence keeps its kind and its timing, and no sequence starts after it ends.
- R9: `bus_grant` is sampled only while the block waits for it. Dropping the grant later does not stop the sequence. `bus_req` stays 1 from acceptance to the end of an enter or exit sequence.
- R10: Asserted reset drives `tgt_reset` to the level of `RST_ACTIVE_HIGH` (1 or 0); released reset drives the opposite level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond (delay time base) |
| enter_req | input | 1 | Pulse: start the programming-mode entry sequence |
| exit_req | input | 1 | Pulse: start the return-to-run-mode sequence |
| reset_req | input | 1 | Pulse: start a standalone reset pulse |
| bus_grant | input | 1 | SPI bus arbiter grant |
| bus_req | output | 1 | SPI bus request, held for the whole enter/exit sequence |
| prog_cs_n | output | 1 | Programming-port chip select, active low |
| tgt_reset | output | 1 | Target reset pin, polarity set by RST_ACTIVE_HIGH |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
Every output changes on the edge that samples its cause, so each result is due exactly one edge after the triggering input:

- `busy` and `bus_req` follow an accepted request.
- Chip-select assertion follows a sampled grant.
- Every phase change, and `done`, follows the sampled tick that completes the phase.

The bench drives inputs at the falling edge. A bench model, written from the requirements, advances at the rising edge. All five outputs are compared against that model at the next falling edge, so every check lands in the cycle where its result is due. Directed runs cover each sequence kind, late grants, simultaneous and mid-sequence requests, and a dropped grant. A long random run mixes random ticks, grants and requests.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [2:0] {
    PS_IDLE    = 3'd0,
    PS_BUSREQ  = 3'd1,
    PS_CSSETUP = 3'd2,
    PS_RSTHOLD = 3'd3,
    PS_STARTUP = 3'd4
  } ps_state_t;

  typedef enum logic [1:0] {
    PK_ENTER = 2'd0,
    PK_EXIT  = 2'd1,
    PK_RESET = 2'd2
  } ps_kind_t;

endpackage

// File: rtl/prog_seq_timer.sv
module prog_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = run && tick && (cnt_q == limit - 1'b1);

  // R3: while a timed phase runs, the count never passes its phase length
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/prog_seq_ctrl.sv
module prog_seq_ctrl
  import prog_seq_pkg::*;
#(
  parameter int CNT_W          = 8,
  parameter int CS_SETUP_TICKS = 200,
  parameter int RST_HOLD_TICKS = 100,
  parameter int STARTUP_TICKS  = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter_req,
  input  logic             exit_req,
  input  logic             reset_req,
  input  logic             bus_grant,
  input  logic             expire,
  output ps_state_t        state_d,
  output ps_kind_t         kind_d,
  output logic             finish,
  output logic             tmr_clr,
  output logic             tmr_run,
  output logic [CNT_W-1:0] tmr_limit
);

  ps_state_t state_q;
  ps_kind_t  kind_q;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    finish  = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (enter_req) begin
          kind_d  = PK_ENTER;
          state_d = PS_BUSREQ;
        end else if (exit_req) begin
          kind_d  = PK_EXIT;
          state_d = PS_BUSREQ;
        end else if (reset_req) begin
          kind_d  = PK_RESET;
          state_d = PS_RSTHOLD;
        end
      end
      PS_BUSREQ: begin
        if (bus_grant) begin
          state_d = (kind_q == PK_ENTER) ? PS_CSSETUP : PS_RSTHOLD;
        end
      end
      PS_CSSETUP: if (expire) state_d = PS_RSTHOLD;
      PS_RSTHOLD: if (expire) state_d = PS_STARTUP;
      PS_STARTUP: begin
        if (expire) begin
          state_d = PS_IDLE;
          finish  = 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      kind_q  <= PK_RESET;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
    end
  end

  always_comb begin
    tmr_run = 1'b1;
    unique case (state_q)
      PS_CSSETUP: tmr_limit = CNT_W'(CS_SETUP_TICKS);
      PS_RSTHOLD: tmr_limit = CNT_W'(RST_HOLD_TICKS);
      PS_STARTUP: tmr_limit = CNT_W'(STARTUP_TICKS);
      default: begin
        tmr_limit = CNT_W'(1);
        tmr_run   = 1'b0;
      end
    endcase
  end

  assign tmr_clr = (state_d != state_q);

  // R8: the kind of a running sequence never changes
  a_r8_kind_held: assert property (@(posedge clk) disable iff (rst)
    (state_q != PS_IDLE && $past(state_q) != PS_IDLE) |-> $stable(kind_q));

  // R6: a standalone reset never enters the bus or chip-select phases
  a_r6_no_bus_phase: assert property (@(posedge clk) disable iff (rst)
    (state_q != PS_IDLE && kind_q == PK_RESET) |->
      (state_q != PS_BUSREQ && state_q != PS_CSSETUP));

  // R3: the chip-select setup phase belongs only to the entry sequence
  a_r3_setup_only_enter: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_CSSETUP) |-> (kind_q == PK_ENTER));

endmodule

// File: rtl/prog_seq_pins.sv
module prog_seq_pins
  import prog_seq_pkg::*;
#(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  ps_state_t state_d,
  input  ps_kind_t  kind_d,
  input  logic      finish,
  output logic      bus_req,
  output logic      prog_cs_n,
  output logic      tgt_reset,
  output logic      busy,
  output logic      done
);

  logic rst_on;
  logic cs_on;

  assign rst_on = (state_d == PS_RSTHOLD);
  assign cs_on  = (kind_d == PK_ENTER) &&
                  (state_d == PS_CSSETUP || state_d == PS_RSTHOLD ||
                   state_d == PS_STARTUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      prog_cs_n <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      bus_req   <= (state_d != PS_IDLE) && (kind_d != PK_RESET);
      prog_cs_n <= !cs_on;
      busy      <= (state_d != PS_IDLE);
      done      <= finish;
    end
  end

  generate
    if (RST_ACTIVE_HIGH) begin : g_rst_hi
      always_ff @(posedge clk) begin
        if (rst) tgt_reset <= 1'b0;
        else     tgt_reset <= rst_on;
      end
    end else begin : g_rst_lo
      always_ff @(posedge clk) begin
        if (rst) tgt_reset <= 1'b1;
        else     tgt_reset <= !rst_on;
      end
    end
  endgenerate

endmodule

// File: rtl/prog_mode_seq.sv
module prog_mode_seq
  import prog_seq_pkg::*;
#(
  parameter int CS_SETUP_TICKS  = 200,
  parameter int RST_HOLD_TICKS  = 100,
  parameter int STARTUP_TICKS   = 200,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic enter_req,
  input  logic exit_req,
  input  logic reset_req,
  input  logic bus_grant,
  output logic bus_req,
  output logic prog_cs_n,
  output logic tgt_reset,
  output logic busy,
  output logic done
);

  localparam int MAX_A    = (CS_SETUP_TICKS > RST_HOLD_TICKS) ? CS_SETUP_TICKS : RST_HOLD_TICKS;
  localparam int MAX_T    = (MAX_A > STARTUP_TICKS) ? MAX_A : STARTUP_TICKS;
  localparam int CNT_W    = $clog2(MAX_T + 1);

  ps_state_t        state_d;
  ps_kind_t         kind_d;
  logic             finish;
  logic             tmr_clr;
  logic             tmr_run;
  logic             expire;
  logic [CNT_W-1:0] tmr_limit;

  prog_seq_ctrl #(
    .CNT_W          (CNT_W),
    .CS_SETUP_TICKS (CS_SETUP_TICKS),
    .RST_HOLD_TICKS (RST_HOLD_TICKS),
    .STARTUP_TICKS  (STARTUP_TICKS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enter_req (enter_req),
    .exit_req  (exit_req),
    .reset_req (reset_req),
    .bus_grant (bus_grant),
    .expire    (expire),
    .state_d   (state_d),
    .kind_d    (kind_d),
    .finish    (finish),
    .tmr_clr   (tmr_clr),
    .tmr_run   (tmr_run),
    .tmr_limit (tmr_limit)
  );

  prog_seq_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (tmr_clr),
    .run    (tmr_run),
    .tick   (ms_tick),
    .limit  (tmr_limit),
    .expire (expire)
  );

  prog_seq_pins #(
    .RST_ACTIVE_HIGH (RST_ACTIVE_HIGH)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .kind_d    (kind_d),
    .finish    (finish),
    .bus_req   (bus_req),
    .prog_cs_n (prog_cs_n),
    .tgt_reset (tgt_reset),
    .busy      (busy),
    .done      (done)
  );

  // R9: chip select is only active while the bus is held
  a_r9_cs_under_bus: assert property (@(posedge clk) disable iff (rst)
    !prog_cs_n |-> bus_req);

  // R2: chip select goes active only on the edge after a sampled grant
  a_r2_cs_after_grant: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_cs_n) |-> $past(bus_grant));

  // R4: done lasts one cycle and coincides with the end of busy
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R10: reset pin is never asserted while idle
  a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tgt_reset == !RST_ACTIVE_HIGH));

endmodule

// File: tb/prog_mode_seq_test.sv
module prog_mode_seq_test;

  localparam int SETUP = 2;
  localparam int HOLD  = 3;
  localparam int START = 4;
  localparam bit RPOL  = 1'b0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0, enter_req = 1'b0, exit_req = 1'b0, reset_req = 1'b0, bus_grant = 1'b0;
  logic bus_req, prog_cs_n, tgt_reset, busy, done;

  always #5 clk = ~clk;

  prog_mode_seq #(
    .CS_SETUP_TICKS (SETUP),
    .RST_HOLD_TICKS (HOLD),
    .STARTUP_TICKS  (START),
    .RST_ACTIVE_HIGH(RPOL)
  ) uut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .enter_req(enter_req),
    .exit_req(exit_req), .reset_req(reset_req), .bus_grant(bus_grant),
    .bus_req(bus_req), .prog_cs_n(prog_cs_n), .tgt_reset(tgt_reset),
    .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_tag = "R1";
  bit rand_tick = 0;
  bit rand_grant = 0;
  logic grant_lvl = 1'b0;
  int tick_ph = 0;

  // bench model: 0 idle, 1 bus wait, 2 cs setup, 3 reset hold, 4 startup
  // kind: 0 enter, 1 exit, 2 standalone reset
  int m_st = 0;
  int m_kind = 2;
  int m_cnt = 0;
  bit m_done = 0;

  function automatic int lim_of(int st);
    if (st == 2) return SETUP;
    if (st == 3) return HOLD;
    return START;
  endfunction

  always @(posedge clk) begin
    m_done <= 1'b0;
    if (rst) begin
      m_st <= 0; m_kind <= 2; m_cnt <= 0;
    end else begin
      case (m_st)
        0: begin
          m_cnt <= 0;
          if (enter_req)      begin m_kind <= 0; m_st <= 1; end
          else if (exit_req)  begin m_kind <= 1; m_st <= 1; end
          else if (reset_req) begin m_kind <= 2; m_st <= 3; end
        end
        1: if (bus_grant) begin m_st <= (m_kind == 0) ? 2 : 3; m_cnt <= 0; end
        default: if (ms_tick) begin
          if (m_cnt == lim_of(m_st) - 1) begin
            m_cnt <= 0;
            m_st  <= (m_st == 4) ? 0 : m_st + 1;
            if (m_st == 4) m_done <= 1'b1;
          end else begin
            m_cnt <= m_cnt + 1;
          end
        end
      endcase
    end
  end

  task automatic chk(input string sig, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_tag, sig, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("bus_req (R9)", bus_req, (m_st != 0) && (m_kind != 2));
    chk("prog_cs_n (R3)", prog_cs_n, !((m_kind == 0) && (m_st >= 2)));
    chk("tgt_reset (R10)", tgt_reset, (m_st == 3) ? RPOL : !RPOL);
    chk("busy (R8)", busy, m_st != 0);
    chk("done (R4)", done, m_done);
  endtask

  task automatic cyc(input logic en, input logic ex, input logic rs);
    @(negedge clk);
    compare();
    enter_req = en; exit_req = ex; reset_req = rs;
    tick_ph = (tick_ph + 1) % 3;
    ms_tick = rand_tick ? (($urandom % 3) == 0) : (tick_ph == 0);
    bus_grant = rand_grant ? ($urandom % 2 == 1) : grant_lvl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      cyc(1'b0, 1'b0, 1'b0);
      if (m_st == 0 && !m_done) break;
    end
    idle(2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk("bus_req in reset", bus_req, 1'b0);
    chk("prog_cs_n in reset", prog_cs_n, 1'b1);
    chk("tgt_reset in reset", tgt_reset, !RPOL);
    chk("busy in reset", busy, 1'b0);
    chk("done in reset", done, 1'b0);
    rst = 1'b0;
    idle(3);

    cur_tag = "R2";          // late grant: cs must wait
    grant_lvl = 1'b0;
    cyc(1'b1, 1'b0, 1'b0);
    idle(7);
    grant_lvl = 1'b1;
    wait_idle();

    cur_tag = "R3";          // grant already present
    cyc(1'b1, 1'b0, 1'b0);
    wait_idle();

    cur_tag = "R4";
    cyc(1'b1, 1'b0, 1'b0);
    wait_idle();

    cur_tag = "R5";
    grant_lvl = 1'b0;
    cyc(1'b0, 1'b1, 1'b0);
    idle(4);
    grant_lvl = 1'b1;
    wait_idle();

    cur_tag = "R6/R10";
    grant_lvl = 1'b0;
    cyc(1'b0, 1'b0, 1'b1);
    wait_idle();
    grant_lvl = 1'b1;

    cur_tag = "R7";
    cyc(1'b1, 1'b1, 1'b1);
    wait_idle();
    cyc(1'b0, 1'b1, 1'b1);
    wait_idle();

    cur_tag = "R8";
    cyc(1'b1, 1'b0, 1'b0);
    idle(4);
    cyc(1'b0, 1'b1, 1'b1);
    idle(8);
    cyc(1'b1, 1'b1, 1'b1);
    wait_idle();
    cyc(1'b0, 1'b0, 1'b1);
    idle(3);
    cyc(1'b1, 1'b0, 1'b0);
    wait_idle();

    cur_tag = "R9";
    cyc(1'b1, 1'b0, 1'b0);
    idle(3);
    grant_lvl = 1'b0;
    wait_idle();
    grant_lvl = 1'b1;

    cur_tag = "R3";          // random ticks, grants and requests
    rand_tick = 1; rand_grant = 1;
    for (int i = 0; i < 6000; i++) begin
      cyc(($urandom % 40) == 0, ($urandom % 40) == 0, ($urandom % 40) == 0);
    end
    rand_tick = 0; rand_grant = 0;
    wait_idle();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (R4): actual still running expected sequence end");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule